// File: doc/BRIEF.md
# Multi-level coherence transaction controller

This block sits at a shared intermediate cache level, an L2 that several L1 caches share, inside an inclusive hierarchy with MSI-style permissions. Each request that arrives on the upward bus is looked up in a small tag and state array. The lookup places the request in one of three classes, and the controller then runs the phases that class needs.

A hit with enough permission completes at once as a cache-to-cache transfer. A miss, or an exclusive request to a line held only shared, becomes a split transaction: a request goes to the next level, and the original request is answered once that level's response arrives. A hit on a line that another L1 holds modified becomes a hunt-and-gather. The controller sends a write-back action down to the owning L1, waits for the reaction that brings the data and permission back, marks its own copy Modified, and then answers the requester.

The controller handles one transaction at a time. Each tag entry records the line state, a presence bit for each L1, a "modified below" flag and the index of the L1 that owns the line. Data storage and replacement are outside the block.

Top module: `mlc_txn_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid`, `act_valid`, `nl_req_valid`, `nl_timeout` and `proto_err` are 0, and every line is Invalid, so the first request to any address is a split transaction.
- R2: A request that hits a line whose permission suffices is answered in the cycle after acceptance with `rsp_cls`=0 (cache-to-cache), and neither `act_valid` nor `nl_req_valid` is raised. Address bits [IDX_W-1:0] select the set and the bits above them form the tag.
- R3: A miss raises `nl_req_valid` for one cycle, in the cycle after acceptance, carrying the request address and `req_excl`. The answer has `rsp_cls`=1 (split) and comes in the cycle after `nl_rsp_valid` is sampled. A shared fill leaves the line in state S with only the requester's presence bit set.
- R4: An exclusive request (`req_excl`=1) that hits a line in state S is sent to the next level as a split upgrade.
- R5: A request that hits a line modified below in an L1 other than the requester raises `act_valid` for one cycle, in the cycle after acceptance, with `act_dst` set to the owner and `act_addr` set to the line address. The answer has `rsp_cls`=2 (hunt) and comes in the cycle after `rct_valid` is sampled.
- R6: When a shared-read hunt completes, the line becomes Modified at this level with no L1 owner. The old owner keeps a shared copy and the requester's presence bit is added. A later shared read from any L1 and a later exclusive request are then both cache-to-cache.
- R7: When any exclusive request completes, the requester becomes the only present L1 and the owner of a line modified below. A later request to that line from another L1 is a hunt whose action goes to that requester.
- R8: `req_ready` is 0 from acceptance until the cycle after the response. A request held during that time is accepted only after the response, and `rsp_valid` lasts exactly one cycle.
- R9: A reaction (`rct_valid`) that arrives while no action is outstanding changes no line state and produces no response. It sets `proto_err`, which stays 1 until reset.
- R10: Once the controller has waited `timeout_cfg` cycles for a next-level response, `nl_timeout` goes to 1. The controller keeps waiting and keeps `req_ready` at 0, completes normally when `nl_rsp_valid` arrives, and `nl_timeout` then returns to 0.
- R11: A request from the L1 that already owns the line modified below is answered cache-to-cache, with no action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Upward bus request present |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_excl | input | 1 | 1 = exclusive request, 0 = shared read |
| req_src | input | SRC_W | Requesting L1 index |
| req_addr | input | ADDR_W | Line address {tag, set} |
| rsp_valid | output | 1 | One-cycle response to the pending request |
| rsp_src | output | SRC_W | L1 being answered |
| rsp_cls | output | 2 | Class: 0 cache-to-cache, 1 split, 2 hunt |
| rsp_excl | output | 1 | Permission granted is exclusive |
| act_valid | output | 1 | One-cycle write-back action to an L1 |
| act_dst | output | SRC_W | L1 that owns the modified line |
| act_addr | output | ADDR_W | Line address of the action |
| rct_valid | input | 1 | Reaction carrying data and permission back |
| nl_req_valid | output | 1 | One-cycle request to the next level |
| nl_req_addr | output | ADDR_W | Address sent to the next level |
| nl_req_excl | output | 1 | Next-level request wants exclusive permission |
| nl_rsp_valid | input | 1 | Next-level response |
| timeout_cfg | input | TMO_W | Wait limit, in cycles, for a next-level response |
| nl_timeout | output | 1 | Next-level wait has exceeded the limit |
| proto_err | output | 1 | Sticky flag for an unexpected reaction |

## Verification
Two events can fall in the same cycle: a stray reaction can arrive in the very cycle in which a next-level response completes a split transaction. The bench provokes this by raising `rct_valid` and `nl_rsp_valid` together while the controller waits on the next level. It then requires that the split response is still delivered with class 1 one cycle later and that `proto_err` becomes set. A follow-up request to the same line must then be a cache-to-cache hit, which shows that the reaction did not disturb the fill.

// File: rtl/mlc_pkg.sv
package mlc_pkg;
    typedef enum logic [1:0] {
        LS_I = 2'd0,
        LS_S = 2'd1,
        LS_M = 2'd2
    } line_st_t;

    typedef enum logic [1:0] {
        CL_C2C   = 2'd0,
        CL_SPLIT = 2'd1,
        CL_HUNT  = 2'd2
    } txn_cls_t;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_NL_ISSUE,
        FS_NL_WAIT,
        FS_ACT_ISSUE,
        FS_ACT_WAIT,
        FS_RESP
    } fsm_t;
endpackage

// File: rtl/mlc_tag_array.sv
module mlc_tag_array
    import mlc_pkg::*;
#(
    parameter int SETS  = 8,
    parameter int TAG_W = 4,
    parameter int N_L1  = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int SRC_W = $clog2(N_L1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output line_st_t         rd_st,
    output logic [TAG_W-1:0] rd_tag,
    output logic [N_L1-1:0]  rd_pres,
    output logic             rd_below,
    output logic [SRC_W-1:0] rd_own,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  line_st_t         wr_st,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [N_L1-1:0]  wr_pres,
    input  logic             wr_below,
    input  logic [SRC_W-1:0] wr_own
);
    typedef struct packed {
        line_st_t         st;
        logic [TAG_W-1:0] tag;
        logic [N_L1-1:0]  pres;
        logic             below;
        logic [SRC_W-1:0] own;
    } ent_t;

    ent_t wr_ent;
    ent_t ent_all [SETS];

    assign wr_ent = '{st: wr_st, tag: wr_tag, pres: wr_pres, below: wr_below, own: wr_own};

    for (genvar s = 0; s < SETS; s++) begin : g_set
        ent_t ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (we && wr_idx == IDX_W'(s)) begin
                ent_d = wr_ent;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else begin
                ent_q <= ent_d;
            end
        end

        assign ent_all[s] = ent_q;
    end

    ent_t rd_ent;
    assign rd_ent   = ent_all[rd_idx];
    assign rd_st    = rd_ent.st;
    assign rd_tag   = rd_ent.tag;
    assign rd_pres  = rd_ent.pres;
    assign rd_below = rd_ent.below;
    assign rd_own   = rd_ent.own;
endmodule

// File: rtl/mlc_classify.sv
module mlc_classify
    import mlc_pkg::*;
#(
    parameter int TAG_W = 4,
    parameter int SRC_W = 2
) (
    input  line_st_t         st,
    input  logic [TAG_W-1:0] line_tag,
    input  logic             below,
    input  logic [SRC_W-1:0] own,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [SRC_W-1:0] req_src,
    input  logic             req_excl,
    output txn_cls_t         cls
);
    logic hit;
    logic foreign_mod;

    always_comb begin
        hit         = (st != LS_I) && (line_tag == req_tag);
        foreign_mod = hit && (st == LS_M) && below && (own != req_src);
        if (!hit) begin
            cls = CL_SPLIT;
        end else if (foreign_mod) begin
            cls = CL_HUNT;
        end else if (req_excl && st == LS_S) begin
            cls = CL_SPLIT;
        end else begin
            cls = CL_C2C;
        end
    end
endmodule

// File: rtl/mlc_wait_timer.sv
module mlc_wait_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    localparam logic [TMO_W-1:0] CNT_MAX = '1;

    logic [TMO_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!en) begin
            cnt_d = '0;
        end else if (cnt_q == CNT_MAX) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = en && (cnt_q >= limit);
endmodule

// File: rtl/mlc_txn_ctrl.sv
module mlc_txn_ctrl
    import mlc_pkg::*;
#(
    parameter int N_L1  = 4,
    parameter int SETS  = 8,
    parameter int TAG_W = 4,
    parameter int TMO_W = 8,
    localparam int SRC_W  = $clog2(N_L1),
    localparam int IDX_W  = $clog2(SETS),
    localparam int ADDR_W = IDX_W + TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_excl,
    input  logic [SRC_W-1:0]  req_src,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [SRC_W-1:0]  rsp_src,
    output logic [1:0]        rsp_cls,
    output logic              rsp_excl,
    output logic              act_valid,
    output logic [SRC_W-1:0]  act_dst,
    output logic [ADDR_W-1:0] act_addr,
    input  logic              rct_valid,
    output logic              nl_req_valid,
    output logic [ADDR_W-1:0] nl_req_addr,
    output logic              nl_req_excl,
    input  logic              nl_rsp_valid,
    input  logic [TMO_W-1:0]  timeout_cfg,
    output logic              nl_timeout,
    output logic              proto_err
);
    typedef struct packed {
        fsm_t             fsm;
        logic [SRC_W-1:0] src;
        logic [IDX_W-1:0] idx;
        logic [TAG_W-1:0] tag;
        logic             excl;
        txn_cls_t         cls;
        logic [SRC_W-1:0] own;
        logic             perr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [IDX_W-1:0] req_idx;
    logic [TAG_W-1:0] req_tag;
    assign req_idx = req_addr[IDX_W-1:0];
    assign req_tag = req_addr[ADDR_W-1:IDX_W];

    logic             idle;
    logic [IDX_W-1:0] rd_idx;
    line_st_t         rd_st;
    logic [TAG_W-1:0] rd_tag;
    logic [N_L1-1:0]  rd_pres;
    logic             rd_below;
    logic [SRC_W-1:0] rd_own;
    txn_cls_t         cls_w;

    assign idle   = (ctl_q.fsm == FS_IDLE);
    assign rd_idx = idle ? req_idx : ctl_q.idx;

    logic             we;
    logic [IDX_W-1:0] wr_idx;
    line_st_t         wr_st;
    logic [TAG_W-1:0] wr_tag;
    logic [N_L1-1:0]  wr_pres;
    logic             wr_below;
    logic [SRC_W-1:0] wr_own;

    mlc_tag_array #(.SETS(SETS), .TAG_W(TAG_W), .N_L1(N_L1)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_idx),
        .rd_st    (rd_st),
        .rd_tag   (rd_tag),
        .rd_pres  (rd_pres),
        .rd_below (rd_below),
        .rd_own   (rd_own),
        .we       (we),
        .wr_idx   (wr_idx),
        .wr_st    (wr_st),
        .wr_tag   (wr_tag),
        .wr_pres  (wr_pres),
        .wr_below (wr_below),
        .wr_own   (wr_own)
    );

    mlc_classify #(.TAG_W(TAG_W), .SRC_W(SRC_W)) u_cls (
        .st       (rd_st),
        .line_tag (rd_tag),
        .below    (rd_below),
        .own      (rd_own),
        .req_tag  (req_tag),
        .req_src  (req_src),
        .req_excl (req_excl),
        .cls      (cls_w)
    );

    mlc_wait_timer #(.TMO_W(TMO_W)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ctl_q.fsm == FS_NL_WAIT),
        .limit   (timeout_cfg),
        .expired (nl_timeout)
    );

    // selected view of the transaction: live request when idle, latched otherwise
    logic             accept;
    logic [SRC_W-1:0] sel_src;
    logic             sel_excl;
    txn_cls_t         sel_cls;
    logic [N_L1-1:0]  sel_bit;

    always_comb begin
        accept   = idle && req_valid;
        sel_src  = idle ? req_src  : ctl_q.src;
        sel_excl = idle ? req_excl : ctl_q.excl;
        sel_cls  = idle ? cls_w    : ctl_q.cls;
        sel_bit  = N_L1'(1) << sel_src;
    end

    // completion update of the tag entry
    always_comb begin
        we = (accept && cls_w == CL_C2C)
          || (ctl_q.fsm == FS_NL_WAIT  && nl_rsp_valid)
          || (ctl_q.fsm == FS_ACT_WAIT && rct_valid);
        wr_idx   = rd_idx;
        wr_tag   = idle ? req_tag : ctl_q.tag;
        wr_st    = rd_st;
        wr_pres  = rd_pres;
        wr_below = rd_below;
        wr_own   = rd_own;
        if (sel_excl) begin
            wr_st    = LS_M;
            wr_pres  = sel_bit;
            wr_below = 1'b1;
            wr_own   = sel_src;
        end else begin
            case (sel_cls)
                CL_HUNT: begin
                    wr_st    = LS_M;
                    wr_below = 1'b0;
                    wr_pres  = rd_pres | sel_bit;
                end
                CL_SPLIT: begin
                    wr_st    = LS_S;
                    wr_below = 1'b0;
                    wr_pres  = sel_bit;
                    wr_own   = sel_src;
                end
                default: begin
                    wr_pres = rd_pres | sel_bit;
                end
            endcase
        end
    end

    // sequencer next state
    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.perr = ctl_q.perr | (rct_valid && ctl_q.fsm != FS_ACT_WAIT);
        case (ctl_q.fsm)
            FS_IDLE: begin
                if (accept) begin
                    ctl_d.src  = req_src;
                    ctl_d.idx  = req_idx;
                    ctl_d.tag  = req_tag;
                    ctl_d.excl = req_excl;
                    ctl_d.cls  = cls_w;
                    ctl_d.own  = rd_own;
                    case (cls_w)
                        CL_HUNT:  ctl_d.fsm = FS_ACT_ISSUE;
                        CL_SPLIT: ctl_d.fsm = FS_NL_ISSUE;
                        default:  ctl_d.fsm = FS_RESP;
                    endcase
                end
            end
            FS_NL_ISSUE:  ctl_d.fsm = FS_NL_WAIT;
            FS_NL_WAIT:   if (nl_rsp_valid) ctl_d.fsm = FS_RESP;
            FS_ACT_ISSUE: ctl_d.fsm = FS_ACT_WAIT;
            FS_ACT_WAIT:  if (rct_valid) ctl_d.fsm = FS_RESP;
            default:      ctl_d.fsm = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{fsm: FS_IDLE, cls: CL_C2C, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready    = idle;
    assign rsp_valid    = (ctl_q.fsm == FS_RESP);
    assign rsp_src      = ctl_q.src;
    assign rsp_cls      = ctl_q.cls;
    assign rsp_excl     = ctl_q.excl;
    assign act_valid    = (ctl_q.fsm == FS_ACT_ISSUE);
    assign act_dst      = ctl_q.own;
    assign act_addr     = {ctl_q.tag, ctl_q.idx};
    assign nl_req_valid = (ctl_q.fsm == FS_NL_ISSUE);
    assign nl_req_addr  = {ctl_q.tag, ctl_q.idx};
    assign nl_req_excl  = ctl_q.excl;
    assign proto_err    = ctl_q.perr;
endmodule

// File: rtl/mlc_txn_chk.sv
module mlc_txn_chk #(
    parameter int N_L1  = 4,
    parameter int SETS  = 8,
    parameter int TAG_W = 4,
    parameter int TMO_W = 8,
    localparam int SRC_W  = $clog2(N_L1),
    localparam int IDX_W  = $clog2(SETS),
    localparam int ADDR_W = IDX_W + TAG_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [1:0]        rsp_cls,
    input logic              act_valid,
    input logic              rct_valid,
    input logic              nl_req_valid,
    input logic              nl_rsp_valid,
    input logic              nl_timeout,
    input logic              proto_err
);
    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (act_valid) begin
            pend_q <= 1'b1;
        end else if (rct_valid) begin
            pend_q <= 1'b0;
        end
    end

    a_r8_busy_while_answering: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || act_valid || nl_req_valid) |-> !req_ready);

    a_r8_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r5_act_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |=> (!act_valid && !req_ready));

    a_r5_hunt_after_reaction: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_cls == 2'd2) |-> $past(rct_valid));

    a_r3_split_after_nl_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_cls == 2'd1) |-> $past(nl_rsp_valid));

    a_r3_single_port_issue: assert property (@(posedge clk) disable iff (!rst_n)
        nl_req_valid |-> !act_valid);

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    a_r9_stray_reaction: assert property (@(posedge clk) disable iff (!rst_n)
        (rct_valid && !pend_q) |=> proto_err);

    a_r10_keep_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        (nl_timeout && !nl_rsp_valid) |=> (nl_timeout && !rsp_valid && !req_ready));
endmodule

bind mlc_txn_ctrl mlc_txn_chk #(
    .N_L1(N_L1), .SETS(SETS), .TAG_W(TAG_W), .TMO_W(TMO_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .rsp_cls      (rsp_cls),
    .act_valid    (act_valid),
    .rct_valid    (rct_valid),
    .nl_req_valid (nl_req_valid),
    .nl_rsp_valid (nl_rsp_valid),
    .nl_timeout   (nl_timeout),
    .proto_err    (proto_err)
);

// File: tb/sim_mlc_txn_ctrl.sv
module sim_mlc_txn_ctrl;
    localparam int CLK_P  = 10;
    localparam int N_L1   = 4;
    localparam int SETS   = 8;
    localparam int TAG_W  = 4;
    localparam int TMO_W  = 8;
    localparam int SRC_W  = $clog2(N_L1);
    localparam int ADDR_W = $clog2(SETS) + TAG_W;

    localparam logic [ADDR_W-1:0] A_LINE = 7'h13;
    localparam logic [ADDR_W-1:0] B_LINE = 7'h2E;
    localparam logic [ADDR_W-1:0] C_LINE = 7'h09;
    localparam logic [ADDR_W-1:0] D_LINE = 7'h38;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_excl = 1'b0;
    logic [SRC_W-1:0]  req_src = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              rsp_valid;
    logic [SRC_W-1:0]  rsp_src;
    logic [1:0]        rsp_cls;
    logic              rsp_excl;
    logic              act_valid;
    logic [SRC_W-1:0]  act_dst;
    logic [ADDR_W-1:0] act_addr;
    logic              rct_valid = 1'b0;
    logic              nl_req_valid;
    logic [ADDR_W-1:0] nl_req_addr;
    logic              nl_req_excl;
    logic              nl_rsp_valid = 1'b0;
    logic [TMO_W-1:0]  timeout_cfg = 8'd200;
    logic              nl_timeout;
    logic              proto_err;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    mlc_txn_ctrl #(.N_L1(N_L1), .SETS(SETS), .TAG_W(TAG_W), .TMO_W(TMO_W)) u0 (.*);

    task automatic check(input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 1'b0;
        rct_valid = 1'b0;
        nl_rsp_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // present one request; returns at the negedge after the accepting edge
    task automatic issue(input int src, input bit excl, input logic [ADDR_W-1:0] addr);
        check("R8 ready before request", int'(req_ready), 1);
        req_valid = 1'b1;
        req_src   = SRC_W'(src);
        req_excl  = excl;
        req_addr  = addr;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_c2c(input string tag, input int src, input bit excl,
                              input logic [ADDR_W-1:0] addr);
        issue(src, excl, addr);
        check({tag, " c2c rsp_valid"}, int'(rsp_valid), 1);
        check({tag, " c2c class"}, int'(rsp_cls), 0);
        check({tag, " c2c rsp_src"}, int'(rsp_src), src);
        check({tag, " c2c no action"}, int'(act_valid), 0);
        check({tag, " c2c no next-level"}, int'(nl_req_valid), 0);
        @(negedge clk);
        check({tag, " c2c rsp ends"}, int'(rsp_valid), 0);
    endtask

    task automatic expect_split(input string tag, input int src, input bit excl,
                                input logic [ADDR_W-1:0] addr);
        issue(src, excl, addr);
        check({tag, " split nl_req_valid"}, int'(nl_req_valid), 1);
        check({tag, " split nl_req_addr"}, int'(nl_req_addr), int'(addr));
        check({tag, " split nl_req_excl"}, int'(nl_req_excl), int'(excl));
        check({tag, " split no action"}, int'(act_valid), 0);
        @(negedge clk);
        check({tag, " split waits"}, int'(nl_req_valid | rsp_valid | req_ready), 0);
        nl_rsp_valid = 1'b1;
        @(negedge clk);
        nl_rsp_valid = 1'b0;
        check({tag, " split rsp_valid"}, int'(rsp_valid), 1);
        check({tag, " split class"}, int'(rsp_cls), 1);
        check({tag, " split rsp_excl"}, int'(rsp_excl), int'(excl));
        @(negedge clk);
    endtask

    task automatic expect_hunt(input string tag, input int src, input bit excl,
                               input logic [ADDR_W-1:0] addr, input int owner);
        issue(src, excl, addr);
        check({tag, " hunt act_valid"}, int'(act_valid), 1);
        check({tag, " hunt act_dst"}, int'(act_dst), owner);
        check({tag, " hunt act_addr"}, int'(act_addr), int'(addr));
        check({tag, " hunt no next-level"}, int'(nl_req_valid), 0);
        @(negedge clk);
        check({tag, " hunt waits"}, int'(act_valid | rsp_valid | req_ready), 0);
        rct_valid = 1'b1;
        @(negedge clk);
        rct_valid = 1'b0;
        check({tag, " hunt rsp_valid"}, int'(rsp_valid), 1);
        check({tag, " hunt class"}, int'(rsp_cls), 2);
        check({tag, " hunt rsp_src"}, int'(rsp_src), src);
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R1 ready after reset", int'(req_ready), 1);
        check("R1 rsp_valid after reset", int'(rsp_valid), 0);
        check("R1 act_valid after reset", int'(act_valid), 0);
        check("R1 nl_req_valid after reset", int'(nl_req_valid), 0);
        check("R1 nl_timeout after reset", int'(nl_timeout), 0);
        check("R1 proto_err after reset", int'(proto_err), 0);
        expect_split("R1 first access misses", 0, 1'b0, A_LINE);
    endtask

    task automatic t_class_walk();
        expect_c2c("R2 shared hit", 1, 1'b0, A_LINE);
        expect_split("R4 exclusive on shared line upgrades", 2, 1'b1, A_LINE);
        expect_hunt("R5 shared read finds modified below", 3, 1'b0, A_LINE, 2);
        expect_c2c("R6 shared read after gather", 0, 1'b0, A_LINE);
        expect_c2c("R6 exclusive on level-owned line", 1, 1'b1, A_LINE);
        expect_hunt("R7 other L1 after exclusive", 2, 1'b0, A_LINE, 1);
        expect_c2c("R6 exclusive after second gather", 2, 1'b1, A_LINE);
        expect_c2c("R11 owner rereads own line", 2, 1'b0, A_LINE);
        expect_hunt("R7 exclusive hunt", 0, 1'b1, A_LINE, 2);
        expect_hunt("R7 ownership moved to L1 0", 3, 1'b1, A_LINE, 0);
        expect_split("R3 tag conflict misses", 1, 1'b0, 7'h23);
    endtask

    task automatic t_stall();
        issue(0, 1'b0, B_LINE);
        check("R8 split issued", int'(nl_req_valid), 1);
        req_valid = 1'b1;
        req_src   = 2'd3;
        req_excl  = 1'b0;
        req_addr  = B_LINE;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R8 ready low while busy", int'(req_ready), 0);
            check("R8 no early response", int'(rsp_valid), 0);
        end
        nl_rsp_valid = 1'b1;
        @(negedge clk);
        nl_rsp_valid = 1'b0;
        check("R8 first response", int'(rsp_valid), 1);
        check("R8 first response source", int'(rsp_src), 0);
        check("R8 ready low in response cycle", int'(req_ready), 0);
        @(negedge clk);
        check("R8 ready after response", int'(req_ready), 1);
        check("R8 response lasts one cycle", int'(rsp_valid), 0);
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 held request answered", int'(rsp_valid), 1);
        check("R8 held request source", int'(rsp_src), 3);
        check("R8 held request class", int'(rsp_cls), 0);
        @(negedge clk);
    endtask

    task automatic t_timeout();
        timeout_cfg = 8'd5;
        issue(1, 1'b1, C_LINE);
        check("R10 request issued", int'(nl_req_valid), 1);
        repeat (4) @(negedge clk);
        check("R10 no timeout before limit", int'(nl_timeout), 0);
        repeat (4) @(negedge clk);
        check("R10 timeout raised", int'(nl_timeout), 1);
        check("R10 still waiting", int'(req_ready | rsp_valid), 0);
        nl_rsp_valid = 1'b1;
        @(negedge clk);
        nl_rsp_valid = 1'b0;
        check("R10 late response delivered", int'(rsp_valid), 1);
        check("R10 late response class", int'(rsp_cls), 1);
        check("R10 timeout cleared", int'(nl_timeout), 0);
        @(negedge clk);
        timeout_cfg = 8'd200;
        expect_c2c("R10 line filled", 1, 1'b0, C_LINE);
    endtask

    task automatic t_stray_reaction();
        check("R9 flag clear before", int'(proto_err), 0);
        rct_valid = 1'b1;
        @(negedge clk);
        rct_valid = 1'b0;
        check("R9 flag set", int'(proto_err), 1);
        check("R9 no response", int'(rsp_valid), 0);
        check("R9 still idle", int'(req_ready), 1);
        repeat (3) @(negedge clk);
        check("R9 flag sticky", int'(proto_err), 1);
        expect_c2c("R9 line untouched", 1, 1'b0, C_LINE);
    endtask

    task automatic t_collision();
        do_reset();
        issue(2, 1'b0, D_LINE);
        check("R9 collision split issued", int'(nl_req_valid), 1);
        @(negedge clk);
        nl_rsp_valid = 1'b1;
        rct_valid    = 1'b1;
        @(negedge clk);
        nl_rsp_valid = 1'b0;
        rct_valid    = 1'b0;
        check("R3 split completes with stray reaction", int'(rsp_valid), 1);
        check("R3 class kept on collision", int'(rsp_cls), 1);
        check("R9 stray reaction flagged", int'(proto_err), 1);
        @(negedge clk);
        expect_c2c("R9 fill survives collision", 0, 1'b0, D_LINE);
    endtask

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_class_walk();
        t_stall();
        t_timeout();
        t_stray_reaction();
        t_collision();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule